// File: doc/BRIEF.md
# Capture Edge Delay Qualifier

This block sits in front of an input-capture channel and keeps narrow glitches from reaching it. The raw pin first goes through a synchronizer. An edge detector then flags the transitions that the polarity selection accepts. When such an edge appears, the block stores the synchronized level from just before the transition and counts a programmed number of module clocks. When the count ends it samples the input again. It passes a one-clock qualified-edge pulse to the capture logic only when the input now sits at the opposite level. If the input has returned to its old level, the edge is dropped.

A two-bit delay select register sets the window to 256, 512 or 1024 module clocks. Its zero code, which is also the reset value, bypasses the window, and every accepted edge then gives a pulse straight away. The register can be written and read back at any time. A write that changes the select while a window is open abandons that window. The control is a two-state machine. **ST_IDLE** waits for an accepted edge. **ST_COUNT** runs the window. The transitions are: *ST_IDLE to ST_COUNT* on an accepted edge with a non-zero select; *ST_IDLE to ST_IDLE* on an accepted edge in bypass, which pulses at once; *ST_COUNT to ST_IDLE (complete)* when the count reaches its limit, where the level is judged; and *ST_COUNT to ST_IDLE (abort)* when the select value changes.

Top module: `capture_glitch_filter`

## Requirements
- R1: The delay select `dly_rd` resets to 00. After a clock edge with `dly_wr_en` high it reads back `dly_wr_data`.
- R2: `edge_pol` chooses which synchronized transitions count as edges: 00 none, 01 rising only, 10 falling only, 11 both. Transitions of any other kind cause no pulse.
- R3: With select 00 (bypass), an accepted pin change gives a pulse at the third rising clock edge, counted from the edge that first samples the new pin level.
- R4: With select 01, 10 or 11 the window is 256, 512 or 1024 clocks. A confirmed pulse appears at rising edge N+3, counted the same way as in R3.
- R5: At the end of the window a pulse is produced only if the synchronized level is the opposite of the level just before the edge. Otherwise no pulse is produced.
- R6: Edges that arrive while a window is open are ignored. The open window neither restarts nor stretches.
- R7: A write that changes the select value while a window is open ends the window with no pulse. A write of the value already held does not disturb the window.
- R8: `qual_pulse` is high for exactly one clock per confirmed edge.
- R9: After a window ends the counter is back at zero. An edge accepted on the very next clock starts a full new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw capture pin, asynchronous to clk |
| edge_pol | input | 2 | Edge selection: 00 none, 01 rise, 10 fall, 11 both |
| dly_wr_en | input | 1 | Write strobe for the delay select |
| dly_wr_data | input | 2 | New delay select: 00 bypass, 01 256, 10 512, 11 1024 |
| dly_rd | output | 2 | Current delay select |
| qual_pulse | output | 1 | One-clock qualified-edge pulse |

## Verification
The assertions assume that `edge_pol` changes only while the machine is idle. They also assume that, in bypass, accepted edges are not so close together that the pin toggles on every clock. The stimulus holds `edge_pol` fixed for each scenario and changes it only after all windows have closed. Every pin change is held for at least ten clocks, except the deliberate glitches and the mid-window edges used to test R5 and R6, and those stay inside an open window. Select writes during a window happen only at chosen points inside that window.

// File: rtl/cgf_pkg.sv
`timescale 1ns/1ps
package cgf_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } cgf_state_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_ANY  = 2'b11
    } cgf_pol_e;

    localparam logic [1:0] DLY_BYPASS = 2'b00;
endpackage

// File: rtl/cgf_sync.sv
`timescale 1ns/1ps
module cgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cgf_edge_detect.sv
`timescale 1ns/1ps
module cgf_edge_detect
    import cgf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lvl,
    input  cgf_pol_e pol,
    output logic     hit,
    output logic     pre_lvl
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        unique case (pol)
            POL_NONE: hit = 1'b0;
            POL_RISE: hit = rise;
            POL_FALL: hit = fall;
            POL_ANY:  hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    assign pre_lvl = prev_q;
endmodule

// File: rtl/cgf_delay_counter.sv
`timescale 1ns/1ps
module cgf_delay_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + CNT_W'(1);
    end

    assign done  = run && (cnt_q == limit - CNT_W'(1));
    assign count = cnt_q;
endmodule

// File: rtl/capture_glitch_filter.sv
`timescale 1ns/1ps
module capture_glitch_filter
    import cgf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_LOG2   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] edge_pol,
    input  logic       dly_wr_en,
    input  logic [1:0] dly_wr_data,
    output logic [1:0] dly_rd,
    output logic       qual_pulse
);
    localparam int CNT_W = BASE_LOG2 + 3;

    cgf_state_e       state_q, state_d;
    logic [1:0]       sel_q;
    logic             ref_q;
    logic             pulse_q, pulse_d;
    logic             lvl_sync, lvl_pre, edge_hit;
    logic             sel_change, cnt_clear, cnt_run, cnt_done, capture_ref;
    logic [CNT_W-1:0] limit, cnt_val;

    cgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
    );

    cgf_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .pol(cgf_pol_e'(edge_pol)),
        .hit(edge_hit), .pre_lvl(lvl_pre)
    );

    cgf_delay_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .run(cnt_run),
        .limit(limit), .done(cnt_done), .count(cnt_val)
    );

    // window length: 2^(BASE_LOG2 + sel - 1)
    always_comb begin
        limit = CNT_W'(1) << (BASE_LOG2 - 1 + int'(sel_q));
    end

    assign sel_change = dly_wr_en && (dly_wr_data != sel_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_hit && sel_q != DLY_BYPASS) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (sel_change || cnt_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output and datapath control
    always_comb begin
        pulse_d     = 1'b0;
        cnt_run     = 1'b0;
        cnt_clear   = 1'b1;
        capture_ref = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture_ref = edge_hit;
                pulse_d     = edge_hit && (sel_q == DLY_BYPASS);
            end
            ST_COUNT: begin
                cnt_run   = !sel_change;
                cnt_clear = sel_change || cnt_done;
                pulse_d   = !sel_change && cnt_done && (lvl_sync != ref_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= DLY_BYPASS;
            ref_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
            if (capture_ref) ref_q <= lvl_pre;
            if (dly_wr_en)   sel_q <= dly_wr_data;
        end
    end

    assign dly_rd     = sel_q;
    assign qual_pulse = pulse_q;
endmodule

// File: rtl/cgf_checker.sv
`timescale 1ns/1ps
module cgf_checker
    import cgf_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input cgf_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit,
    input logic [1:0]       sel,
    input logic             wr_en,
    input logic [1:0]       wr_data,
    input logic             qual_pulse
);
    p_reset_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sel == 2'b00);

    p_no_count_in_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b00 |-> state == ST_IDLE);

    p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COUNT |-> cnt < limit);

    p_pulse_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        qual_pulse |-> ($past(state) == ST_COUNT || $past(sel) == 2'b00));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && wr_en && wr_data != sel) |=> (state == ST_IDLE && !qual_pulse));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_pulse && sel != 2'b00) |=> !qual_pulse);

    p_idle_cnt_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> cnt == '0);
endmodule

bind capture_glitch_filter cgf_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cnt(cnt_val), .limit(limit),
    .sel(sel_q), .wr_en(dly_wr_en), .wr_data(dly_wr_data), .qual_pulse(qual_pulse)
);

// File: tb/tb_capture_glitch_filter.sv
`timescale 1ns/1ps
module tb_capture_glitch_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic [1:0] edge_pol = 2'b01;
    logic       dly_wr_en = 1'b0;
    logic [1:0] dly_wr_data = 2'b00;
    logic [1:0] dly_rd;
    logic       qual_pulse;

    int    n_checks = 0;
    int    n_fail = 0;
    int    pulses = 0;
    string tag = "R1";
    bit    finished = 0;

    always #5 clk = ~clk;

    capture_glitch_filter dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_pol(edge_pol),
        .dly_wr_en(dly_wr_en), .dly_wr_data(dly_wr_data),
        .dly_rd(dly_rd), .qual_pulse(qual_pulse)
    );

    // behavioural reference model
    bit hist[$];
    bit m_busy, m_ref, m_pulse, cur, old, hit;
    int m_rem;
    logic [1:0] m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_front(1'b0);
            m_busy = 0; m_ref = 0; m_pulse = 0; m_rem = 0; m_sel = 2'b00;
        end else begin
            cur = hist[1];
            old = hist[2];
            hit = (edge_pol[0] && cur && !old) || (edge_pol[1] && !cur && old);
            m_pulse = 0;
            if (m_busy) begin
                if (dly_wr_en && dly_wr_data != m_sel) m_busy = 0;
                else if (m_rem == 1) begin
                    m_busy = 0;
                    m_pulse = (cur != m_ref);
                end else m_rem = m_rem - 1;
            end else if (hit) begin
                if (m_sel == 2'b00) m_pulse = 1;
                else begin
                    m_busy = 1;
                    m_rem = 256 << (int'(m_sel) - 1);
                    m_ref = old;
                end
            end
            if (dly_wr_en) m_sel = dly_wr_data;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (qual_pulse !== m_pulse) begin
                n_fail++;
                $display("FAIL %s: qual_pulse actual %0b expected %0b at %0t", tag, qual_pulse, m_pulse, $time);
            end
            if (dly_rd !== m_sel) begin
                n_fail++;
                $display("FAIL R1: dly_rd actual %0d expected %0d at %0t", dly_rd, m_sel, $time);
            end
            if (qual_pulse) pulses++;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] v);
        @(negedge clk);
        dly_wr_en = 1'b1; dly_wr_data = v;
        @(negedge clk);
        dly_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a new pin level and count edges until the pulse is seen
    task automatic latency(input string req, input logic v, input int exp);
        int n = 0;
        bit found = 0;
        @(negedge clk);
        pin_in = v;
        for (int i = 0; i < 2000 && !found; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (qual_pulse) found = 1;
        end
        check_eq(req, found ? n : -1, exp);
        @(negedge clk);
        check_eq("R8", int'(qual_pulse), 0);
    endtask

    task automatic window(input string req, input int n, input int exp);
        pulses = 0;
        idle(n);
        check_eq(req, pulses, exp);
    endtask

    initial begin
        #(150000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check_eq("R1", int'(dly_rd), 0);
        check_eq("R1", int'(qual_pulse), 0);

        // bypass, rising only
        tag = "R3";
        latency("R3", 1'b1, 3);
        idle(10);
        tag = "R2";
        @(negedge clk); pin_in = 1'b0;
        window("R2", 20, 0);

        // bypass, both edges, then none
        edge_pol = 2'b11;
        latency("R2", 1'b1, 3);
        idle(10);
        latency("R2", 1'b0, 3);
        idle(10);
        edge_pol = 2'b00;
        @(negedge clk); pin_in = 1'b1;
        window("R2", 20, 0);
        @(negedge clk); pin_in = 1'b0;
        window("R2", 20, 0);

        // 256-clock window
        edge_pol = 2'b01;
        tag = "R4";
        write_sel(2'b01);
        check_eq("R1", int'(dly_rd), 1);
        latency("R4", 1'b1, 259);
        idle(10);

        // falling edge ignored, glitch rejected
        tag = "R5";
        @(negedge clk); pin_in = 1'b0;
        window("R2", 300, 0);
        pulses = 0;
        @(negedge clk); pin_in = 1'b1;
        idle(50);
        pin_in = 1'b0;
        idle(400);
        check_eq("R5", pulses, 0);

        // edges inside an open window
        tag = "R6";
        edge_pol = 2'b11;
        pulses = 0;
        @(negedge clk); pin_in = 1'b1;
        idle(100);
        pin_in = 1'b0;
        idle(600);
        check_eq("R6", pulses, 0);
        begin
            int n = 0;
            bit found = 0;
            @(negedge clk); pin_in = 1'b1;
            for (int i = 0; i < 2000 && !found; i++) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (qual_pulse) found = 1;
                else if (n == 100) pin_in = 1'b0;
                else if (n == 150) pin_in = 1'b1;
            end
            check_eq("R6", found ? n : -1, 259);
        end
        // new edge right after completion starts a full window
        tag = "R9";
        latency("R9", 1'b0, 259);
        idle(10);

        // abort on select change, no abort on same value
        tag = "R7";
        edge_pol = 2'b01;
        write_sel(2'b10);
        check_eq("R1", int'(dly_rd), 2);
        pulses = 0;
        @(negedge clk); pin_in = 1'b1;
        idle(100);
        dly_wr_en = 1'b1; dly_wr_data = 2'b11;
        @(negedge clk);
        dly_wr_en = 1'b0;
        idle(1200);
        check_eq("R7", pulses, 0);
        @(negedge clk); pin_in = 1'b0;
        idle(20);
        write_sel(2'b10);
        begin
            int n = 0;
            bit found = 0;
            @(negedge clk); pin_in = 1'b1;
            for (int i = 0; i < 2000 && !found; i++) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (qual_pulse) found = 1;
                else if (n == 100) begin dly_wr_en = 1'b1; dly_wr_data = 2'b10; end
                else if (n == 101) dly_wr_en = 1'b0;
            end
            dly_wr_en = 1'b0;
            check_eq("R7", found ? n : -1, 515);
        end

        // 1024-clock window
        tag = "R4";
        @(negedge clk); pin_in = 1'b0;
        idle(10);
        write_sel(2'b11);
        latency("R4", 1'b1, 1027);
        idle(10);

        // back to bypass
        tag = "R3";
        write_sel(2'b00);
        @(negedge clk); pin_in = 1'b0;
        idle(10);
        latency("R3", 1'b1, 3);
        idle(10);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule